// File: doc/BRIEF.md
# Wormhole Packet Routing Switch

This block is an eleven-port packet switch that forwards each incoming packet to one output using wormhole routing: nothing is stored beyond a single header byte. Every port, inbound and outbound, carries an 8-bit data byte plus a control flag over a valid/ready handshake. A flit with the flag set is the end-of-packet marker. The first byte of a packet names its destination. Port 0 is the internal configuration port, ports 1 to 8 are link ports and ports 9 and 10 are parallel ports. The switch treats all eleven ports identically.

A leading byte below 32 is a path address. It gives the output port number directly and is removed before forwarding, so a multi-hop route is written as a string of such bytes that are consumed one per switch. A leading byte of 32 or above is a logical address. It is looked up in a routing table, which supplies the output port and a priority, and it is forwarded unchanged. Once granted, an output stays connected to its input until the end-of-packet marker has passed. Inputs that compete for a busy output wait. When the output is released, the highest priority wins, and among equal priorities a round-robin pointer kept per output picks the next input after the one granted last. The table is filled through a write port of its own.

Top module: `wh_switch`

## Requirements
- R1: After reset, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A packet whose first byte is a path address below 11 leaves on the port with that number. The first byte is removed. Every following byte, including later address bytes and the end-of-packet flit (control flag 1, data unchanged), is forwarded in order.
- R3: A packet whose first byte is 32 or above, with a table entry marked valid, leaves on the port the entry names. The first byte is forwarded unchanged as an ordinary data flit. Table entries are written at the table address equal to that byte.
- R4: A packet whose first byte is a path address from 11 to 31, or a logical address whose entry is invalid or names a port of 11 or above, is accepted and discarded up to and including its end-of-packet flit. Nothing appears on any output, and the input then accepts a new packet.
- R5: An output granted to an input stays connected to it until that input's end-of-packet flit has transferred. Other inputs that want that output keep `in_ready` low, and their packets are delivered intact afterwards.
- R6: When several inputs wait on one output, the highest table priority is granted first. A larger priority value wins, and path-addressed packets have priority 0.
- R7: Among waiting inputs of equal priority, the grant goes to the first one above the input granted last on that output, wrapping from 10 to 0. After reset each pointer stands at input 10.
- R8: A flit with the control flag set that arrives where a header is expected is consumed and produces no output.
- R9: While `out_ready` of a connected output is low, its `out_valid`, data and flag are held, and the source input keeps `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 11 | Per-input flit valid |
| in_data | input | 88 | Per-input data byte, input p at bits p*8+7..p*8 |
| in_eop | input | 11 | Per-input control flag, 1 marks end of packet |
| in_ready | output | 11 | Per-input flit accepted when high with valid |
| out_valid | output | 11 | Per-output flit valid |
| out_data | output | 88 | Per-output data byte, output p at bits p*8+7..p*8 |
| out_eop | output | 11 | Per-output control flag |
| out_ready | input | 11 | Per-output downstream ready |
| tbl_we | input | 1 | Routing table write strobe |
| tbl_addr | input | 8 | Logical address written (32..255; lower values are ignored) |
| tbl_valid | input | 1 | Entry valid bit written |
| tbl_port | input | 4 | Output port stored in the entry |
| tbl_prio | input | 2 | Priority stored in the entry |

## Verification
A wrong per-output owner or busy bit shows at once as bytes from the wrong input, or from two packets interleaved, on one output. The per-output scoreboard flags this on the first misplaced flit. A stuck input state shows as an input whose `in_ready` never returns, or as a follow-up packet that never arrives; the drain check at the end of the run reports it. A corrupt round-robin pointer or priority compare changes the order in which queued packets appear on a contended output. That shows within the first packet after the blocking packet releases the port.

// File: rtl/wh_pkg.sv
package wh_pkg;
    localparam int NPORT      = 11;
    localparam int PIDX_W     = $clog2(NPORT);
    localparam int PRIO_W     = 2;
    localparam int BYTE_W     = 8;
    localparam int PATH_LIMIT = 32;
    localparam int TBL_DEPTH  = (1 << BYTE_W) - PATH_LIMIT;

    typedef struct packed {
        logic              eop;
        logic [BYTE_W-1:0] data;
    } flit_t;

    typedef struct packed {
        logic              valid;
        logic [PIDX_W-1:0] port;
        logic [PRIO_W-1:0] prio;
    } route_t;

    typedef enum logic [1:0] {
        S_HEAD = 2'd0,
        S_REQ  = 2'd1,
        S_DROP = 2'd2
    } in_state_e;

    function automatic logic is_path(input logic [BYTE_W-1:0] b);
        return int'(b) < PATH_LIMIT;
    endfunction
endpackage

// File: rtl/wh_route_table.sv
module wh_route_table import wh_pkg::*; (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [BYTE_W-1:0]             wr_addr,
    input  route_t                        wr_entry,
    input  logic [NPORT-1:0][BYTE_W-1:0]  rd_addr,
    output route_t [NPORT-1:0]            rd_entry
);
    route_t mem [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TBL_DEPTH; k++) mem[k] <= '0;
        end else if (wr_en && !is_path(wr_addr)) begin
            mem[int'(wr_addr) - PATH_LIMIT] <= wr_entry;
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            if (is_path(rd_addr[p])) rd_entry[p] = '0;
            else                     rd_entry[p] = mem[int'(rd_addr[p]) - PATH_LIMIT];
        end
    end
endmodule

// File: rtl/wh_input_unit.sv
module wh_input_unit import wh_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  flit_t             in_flit,
    output logic              in_ready,
    input  route_t            lookup,
    input  logic              granted,
    input  logic              dst_ready,
    output logic              req,
    output logic [PIDX_W-1:0] req_port,
    output logic [PRIO_W-1:0] req_prio,
    output logic              src_valid,
    output flit_t             src_flit
);
    in_state_e         st_q;
    logic              hdr_pend_q;
    logic [BYTE_W-1:0] hdr_q;
    logic              take;
    logic              path_ok;
    logic              logic_ok;

    always_comb begin
        path_ok  = is_path(in_flit.data) && (int'(in_flit.data) < NPORT);
        logic_ok = !is_path(in_flit.data) && lookup.valid && (int'(lookup.port) < NPORT);
        req       = (st_q == S_REQ);
        src_valid = req && granted && (hdr_pend_q || in_valid);
        src_flit  = hdr_pend_q ? flit_t'({1'b0, hdr_q}) : in_flit;
        if (st_q == S_REQ) in_ready = granted && !hdr_pend_q && dst_ready;
        else               in_ready = 1'b1;
        take = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_HEAD;
            hdr_pend_q <= 1'b0;
            hdr_q      <= '0;
            req_port   <= '0;
            req_prio   <= '0;
        end else begin
            unique case (st_q)
                S_HEAD: if (take && !in_flit.eop) begin
                    if (path_ok) begin
                        st_q       <= S_REQ;
                        hdr_pend_q <= 1'b0;
                        req_port   <= PIDX_W'(in_flit.data);
                        req_prio   <= '0;
                    end else if (logic_ok) begin
                        st_q       <= S_REQ;
                        hdr_pend_q <= 1'b1;
                        hdr_q      <= in_flit.data;
                        req_port   <= lookup.port;
                        req_prio   <= lookup.prio;
                    end else begin
                        st_q <= S_DROP;
                    end
                end
                S_REQ: begin
                    if (granted && hdr_pend_q && dst_ready) hdr_pend_q <= 1'b0;
                    if (take && in_flit.eop) st_q <= S_HEAD;
                end
                S_DROP: if (take && in_flit.eop) st_q <= S_HEAD;
                default: st_q <= S_HEAD;
            endcase
        end
    end

    // R9: a stalled flit toward the output is held unchanged
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (src_valid && !dst_ready) |=> (src_valid && $stable(src_flit)));
endmodule

// File: rtl/wh_out_arbiter.sv
module wh_out_arbiter import wh_pkg::*; #(
    parameter int OIDX = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORT-1:0]              req_vec,
    input  logic [NPORT-1:0][PIDX_W-1:0]  req_port,
    input  logic [NPORT-1:0][PRIO_W-1:0]  req_prio,
    input  logic                          eop_fire,
    output logic                          busy,
    output logic [PIDX_W-1:0]             owner
);
    logic [NPORT-1:0]  hit;
    logic [PRIO_W-1:0] top_prio;
    logic              any_hit;
    logic              found;
    logic [PIDX_W-1:0] winner;
    logic [PIDX_W-1:0] ptr_q;

    always_comb begin
        top_prio = '0;
        any_hit  = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            hit[i] = req_vec[i] && (req_port[i] == PIDX_W'(OIDX));
            if (hit[i]) begin
                any_hit = 1'b1;
                if (req_prio[i] > top_prio) top_prio = req_prio[i];
            end
        end
        found  = 1'b0;
        winner = ptr_q;
        for (int k = 1; k <= NPORT; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % NPORT;
            if (!found && hit[idx] && (req_prio[idx] == top_prio)) begin
                found  = 1'b1;
                winner = PIDX_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            owner <= '0;
            ptr_q <= PIDX_W'(NPORT - 1);
        end else if (busy) begin
            if (eop_fire) busy <= 1'b0;
        end else if (any_hit) begin
            busy  <= 1'b1;
            owner <= winner;
            ptr_q <= winner;
        end
    end

    // R5: the connection holds until the end-of-packet flit leaves
    a_r5_lock_until_eop: assert property (@(posedge clk) disable iff (rst)
        (busy && !eop_fire) |=> (busy && $stable(owner)));

    // R6: a new connection only goes to an input that asked for this output
    a_r6_grant_had_request: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ((($past(hit) >> owner) & 1) != 0));
endmodule

// File: rtl/wh_switch.sv
module wh_switch import wh_pkg::*; (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORT-1:0]         in_valid,
    input  logic [NPORT*BYTE_W-1:0]  in_data,
    input  logic [NPORT-1:0]         in_eop,
    output logic [NPORT-1:0]         in_ready,
    output logic [NPORT-1:0]         out_valid,
    output logic [NPORT*BYTE_W-1:0]  out_data,
    output logic [NPORT-1:0]         out_eop,
    input  logic [NPORT-1:0]         out_ready,
    input  logic                     tbl_we,
    input  logic [BYTE_W-1:0]        tbl_addr,
    input  logic                     tbl_valid,
    input  logic [PIDX_W-1:0]        tbl_port,
    input  logic [PRIO_W-1:0]        tbl_prio
);
    logic [NPORT-1:0][BYTE_W-1:0] rd_addr;
    route_t [NPORT-1:0]           rd_entry;
    logic [NPORT-1:0]             req;
    logic [NPORT-1:0][PIDX_W-1:0] req_port;
    logic [NPORT-1:0][PRIO_W-1:0] req_prio;
    logic [NPORT-1:0]             src_valid;
    flit_t [NPORT-1:0]            src_flit;
    logic [NPORT-1:0]             busy;
    logic [NPORT-1:0][PIDX_W-1:0] owner;
    logic [NPORT-1:0]             eop_fire;
    logic [NPORT-1:0]             granted;
    logic [NPORT-1:0]             dst_ready;
    logic [NPORT-1:0][NPORT-1:0]  conn;

    wh_route_table u_table (
        .clk(clk), .rst(rst), .wr_en(tbl_we), .wr_addr(tbl_addr),
        .wr_entry('{valid: tbl_valid, port: tbl_port, prio: tbl_prio}),
        .rd_addr(rd_addr), .rd_entry(rd_entry)
    );

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++)
                conn[i][o] = busy[o] && (owner[o] == PIDX_W'(i));
            granted[i]   = |conn[i];
            dst_ready[i] = out_ready[req_port[i]];
        end
        for (int o = 0; o < NPORT; o++) begin
            out_valid[o]                 = busy[o] && src_valid[owner[o]];
            out_data[o*BYTE_W +: BYTE_W] = src_flit[owner[o]].data;
            out_eop[o]                   = busy[o] && src_flit[owner[o]].eop;
            eop_fire[o]                  = out_valid[o] && out_ready[o] && out_eop[o];
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        assign rd_addr[i] = in_data[i*BYTE_W +: BYTE_W];
        wh_input_unit u_in (
            .clk(clk), .rst(rst),
            .in_valid(in_valid[i]),
            .in_flit(flit_t'({in_eop[i], in_data[i*BYTE_W +: BYTE_W]})),
            .in_ready(in_ready[i]), .lookup(rd_entry[i]),
            .granted(granted[i]), .dst_ready(dst_ready[i]),
            .req(req[i]), .req_port(req_port[i]), .req_prio(req_prio[i]),
            .src_valid(src_valid[i]), .src_flit(src_flit[i])
        );
        // R5: one input is never connected to two outputs at once
        a_r5_single_conn: assert property (@(posedge clk) disable iff (rst)
            $onehot0(conn[i]));
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_arb
        wh_out_arbiter #(.OIDX(o)) u_arb (
            .clk(clk), .rst(rst), .req_vec(req), .req_port(req_port),
            .req_prio(req_prio), .eop_fire(eop_fire[o]),
            .busy(busy[o]), .owner(owner[o])
        );
    end
endmodule

// File: tb/wh_switch_tb.sv
`timescale 1ns/1ps
module wh_switch_tb;
    localparam int NP = 11;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   in_valid = '0;
    logic [NP*8-1:0] in_data = '0;
    logic [NP-1:0]   in_eop = '0;
    logic [NP-1:0]   in_ready;
    logic [NP-1:0]   out_valid;
    logic [NP*8-1:0] out_data;
    logic [NP-1:0]   out_eop;
    logic [NP-1:0]   out_ready = '1;
    logic            tbl_we = 1'b0;
    logic [7:0]      tbl_addr = '0;
    logic            tbl_valid = 1'b0;
    logic [3:0]      tbl_port = '0;
    logic [1:0]      tbl_prio = '0;

    int checks = 0;
    int errors = 0;
    int cur_req = 1;
    logic [12:0] exp_q [NP][$];

    always #4 clk = ~clk;

    wh_switch u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop),
        .out_ready(out_ready), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_valid(tbl_valid),
        .tbl_port(tbl_port), .tbl_prio(tbl_prio)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic exp_flit(input int dst, input int rq, input logic eop, input logic [7:0] d);
        exp_q[dst].push_back({4'(rq), eop, d});
    endtask

    task automatic put_flit(input int src, input logic eop, input logic [7:0] d);
        @(negedge clk);
        in_valid[src] = 1'b1;
        in_eop[src] = eop;
        in_data[src*8 +: 8] = d;
        #1;
        while (!in_ready[src]) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 in_valid[src] = 1'b0;
    endtask

    task automatic tbl_write(input logic [7:0] a, input logic v, input logic [3:0] p, input logic [1:0] pr);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a; tbl_valid = v; tbl_port = p; tbl_prio = pr;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // scoreboard monitor: a transfer is decided when valid and ready are seen after the negedge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    logic [8:0] got;
                    logic [12:0] e;
                    got = {out_eop[o], out_data[o*8 +: 8]};
                    checks++;
                    if (exp_q[o].size() == 0) begin
                        errors++;
                        $display("FAIL R%0d unexpected flit on output %0d actual=%0h expected=none",
                                 cur_req, o, got);
                    end else begin
                        e = exp_q[o].pop_front();
                        if (e[8:0] !== got) begin
                            errors++;
                            $display("FAIL R%0d output %0d actual=%0h expected=%0h",
                                     e[12:9], o, got, e[8:0]);
                        end
                    end
                end
            end
        end
    end

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #3;
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        check("R1 in_ready after reset", 32'(in_ready), 32'(11'h7FF));

        tbl_write(8'd100, 1'b1, 4'd9, 2'd0);
        tbl_write(8'd40,  1'b1, 4'd3, 2'd1);
        tbl_write(8'd50,  1'b1, 4'd3, 2'd3);
        tbl_write(8'd60,  1'b1, 4'd0, 2'd2);
        tbl_write(8'd101, 1'b0, 4'd2, 2'd0);
        tbl_write(8'd102, 1'b1, 4'd12, 2'd0);

        // R2: path addressing, first byte stripped, second hop byte kept
        cur_req = 2;
        exp_flit(2, 2, 0, 8'h07); exp_flit(2, 2, 0, 8'hAA); exp_flit(2, 2, 0, 8'hBB); exp_flit(2, 2, 1, 8'h00);
        exp_flit(10, 2, 0, 8'h11); exp_flit(10, 2, 1, 8'h5E);
        fork
            begin put_flit(0, 0, 8'd2); put_flit(0, 0, 8'h07); put_flit(0, 0, 8'hAA); put_flit(0, 0, 8'hBB); put_flit(0, 1, 8'h00); end
            begin put_flit(4, 0, 8'd10); put_flit(4, 0, 8'h11); put_flit(4, 1, 8'h5E); end
        join
        repeat (6) @(negedge clk);
        check("R2 output 2 drained", 32'(exp_q[2].size()), 32'd0);
        check("R2 output 10 drained", 32'(exp_q[10].size()), 32'd0);

        // R3: logical addressing, header passed unchanged
        cur_req = 3;
        exp_flit(9, 3, 0, 8'd100); exp_flit(9, 3, 0, 8'h5A); exp_flit(9, 3, 1, 8'h00);
        exp_flit(0, 3, 0, 8'd60);  exp_flit(0, 3, 0, 8'hC3); exp_flit(0, 3, 1, 8'h01);
        fork
            begin put_flit(3, 0, 8'd100); put_flit(3, 0, 8'h5A); put_flit(3, 1, 8'h00); end
            begin put_flit(6, 0, 8'd60);  put_flit(6, 0, 8'hC3); put_flit(6, 1, 8'h01); end
        join
        repeat (6) @(negedge clk);
        check("R3 output 9 drained", 32'(exp_q[9].size()), 32'd0);
        check("R3 output 0 drained", 32'(exp_q[0].size()), 32'd0);

        // R4: discarded packets (path 15, invalid entry 101, entry 102 naming port 12)
        cur_req = 4;
        put_flit(5, 0, 8'd15);  put_flit(5, 0, 8'h01); put_flit(5, 0, 8'h02); put_flit(5, 1, 8'h03);
        put_flit(7, 0, 8'd101); put_flit(7, 0, 8'h04); put_flit(7, 1, 8'h05);
        put_flit(8, 0, 8'd102); put_flit(8, 1, 8'h06);
        repeat (4) @(negedge clk); #3;
        check("R4 no output after discard", 32'(out_valid), 32'd0);
        check("R4 inputs ready again", 32'(in_ready), 32'(11'h7FF));
        exp_flit(1, 4, 0, 8'h77); exp_flit(1, 4, 1, 8'h00);
        put_flit(5, 0, 8'd1); put_flit(5, 0, 8'h77); put_flit(5, 1, 8'h00);
        repeat (6) @(negedge clk);
        check("R4 follow-up packet delivered", 32'(exp_q[1].size()), 32'd0);

        // R8: end-of-packet flit in header position is consumed silently
        cur_req = 8;
        exp_flit(4, 8, 0, 8'h99); exp_flit(4, 8, 1, 8'h00);
        put_flit(2, 1, 8'd4); put_flit(2, 0, 8'd4); put_flit(2, 0, 8'h99); put_flit(2, 1, 8'h00);
        repeat (6) @(negedge clk);
        check("R8 only the real packet on output 4", 32'(exp_q[4].size()), 32'd0);

        // R9: backpressure holds the flit
        cur_req = 9;
        exp_flit(5, 9, 0, 8'h10); exp_flit(5, 9, 0, 8'h20); exp_flit(5, 9, 1, 8'h00);
        @(negedge clk); out_ready[5] = 1'b0;
        fork
            begin put_flit(8, 0, 8'd5); put_flit(8, 0, 8'h10); put_flit(8, 0, 8'h20); put_flit(8, 1, 8'h00); end
            begin
                repeat (8) @(negedge clk); #3;
                check("R9 out_valid held", 32'(out_valid[5]), 32'd1);
                check("R9 data held", 32'(out_data[5*8 +: 8]), 32'h10);
                check("R9 source stalled", 32'(in_ready[8]), 32'd0);
                @(negedge clk);
                out_ready[5] = 1'b1;
            end
        join
        repeat (6) @(negedge clk);

        // R5 and R6: blocker holds output 3, then priority decides
        cur_req = 6;
        exp_flit(3, 5, 0, 8'hA1); exp_flit(3, 5, 0, 8'hA2); exp_flit(3, 5, 1, 8'h00);
        exp_flit(3, 6, 0, 8'd50); exp_flit(3, 6, 0, 8'hC1); exp_flit(3, 6, 1, 8'h00);
        exp_flit(3, 6, 0, 8'd40); exp_flit(3, 6, 0, 8'hB1); exp_flit(3, 6, 1, 8'h00);
        fork
            begin
                put_flit(1, 0, 8'd3); put_flit(1, 0, 8'hA1); put_flit(1, 0, 8'hA2);
                repeat (12) @(negedge clk); #3;
                check("R5 held output idle while blocker pauses", 32'(out_valid[3]), 32'd0);
                check("R5 contender 2 stalled", 32'(in_ready[2]), 32'd0);
                check("R5 contender 4 stalled", 32'(in_ready[4]), 32'd0);
                put_flit(1, 1, 8'h00);
            end
            begin repeat (5) @(negedge clk); put_flit(2, 0, 8'd40); put_flit(2, 0, 8'hB1); put_flit(2, 1, 8'h00); end
            begin repeat (5) @(negedge clk); put_flit(4, 0, 8'd50); put_flit(4, 0, 8'hC1); put_flit(4, 1, 8'h00); end
        join
        repeat (6) @(negedge clk);
        check("R6 output 3 drained", 32'(exp_q[3].size()), 32'd0);

        // R7: equal priority round robin, pointer after input 1 then after input 7
        cur_req = 7;
        exp_flit(6, 7, 0, 8'hD1); exp_flit(6, 7, 1, 8'h00);
        exp_flit(6, 7, 0, 8'h22); exp_flit(6, 7, 1, 8'h00);
        exp_flit(6, 7, 0, 8'h25); exp_flit(6, 7, 1, 8'h00);
        exp_flit(6, 7, 0, 8'h28); exp_flit(6, 7, 1, 8'h00);
        exp_flit(6, 7, 0, 8'hE1); exp_flit(6, 7, 1, 8'h00);
        exp_flit(6, 7, 0, 8'h38); exp_flit(6, 7, 1, 8'h00);
        exp_flit(6, 7, 0, 8'h32); exp_flit(6, 7, 1, 8'h00);
        exp_flit(6, 7, 0, 8'h35); exp_flit(6, 7, 1, 8'h00);
        for (int round = 0; round < 2; round++) begin
            int blk;
            blk = (round == 0) ? 1 : 7;
            fork
                begin
                    put_flit(blk, 0, 8'd6); put_flit(blk, 0, (round == 0) ? 8'hD1 : 8'hE1);
                    repeat (14) @(negedge clk);
                    put_flit(blk, 1, 8'h00);
                end
                begin repeat (5) @(negedge clk); put_flit(2, 0, 8'd6); put_flit(2, 0, 8'(8'h22 + round*16)); put_flit(2, 1, 8'h00); end
                begin repeat (5) @(negedge clk); put_flit(5, 0, 8'd6); put_flit(5, 0, 8'(8'h25 + round*16)); put_flit(5, 1, 8'h00); end
                begin repeat (5) @(negedge clk); put_flit(8, 0, 8'd6); put_flit(8, 0, 8'(8'h28 + round*16)); put_flit(8, 1, 8'h00); end
            join
            repeat (6) @(negedge clk);
        end
        check("R7 output 6 drained", 32'(exp_q[6].size()), 32'd0);

        repeat (20) @(negedge clk);
        for (int o = 0; o < NP; o++)
            check("R2 final drain of every output", 32'(exp_q[o].size()), 32'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (50000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog for all requirements actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule